// File: doc/BRIEF.md
# Linked-Descriptor Copy Channel Sequencer and Registers

This block is one copy channel of a descriptor-driven DMA engine, reduced to its control registers and the sequencer that walks a chain of descriptors held in memory. Software places descriptors in memory, writes the address of the first descriptor into the next-pointer register, and sets the enable bit. The channel reads each descriptor word by word through a simple request/acknowledge read port. It hands each transfer (source, destination, length, transaction code, copy mode) to an external data mover and follows the chain until it reaches a descriptor whose link word is zero.

Completion of each descriptor and the end of the chain are recorded as sticky status flags that software clears by writing ones. Mover faults are recorded the same way and halt the channel. A stopped chain can be extended: software links a new descriptor behind the last one and sets the append bit, and the channel re-reads the last descriptor's link word and carries on. An interrupt line follows the end-of-transfer flag when a completed descriptor asked for it.

Top module: `chain_dma_ch`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control: bit 0 enable, bit 1 append pending), 0x04 (status), 0x0C (current descriptor address, read-only), 0x10 (next descriptor pointer, read/write) and 0x20 (current byte count, read-only). After reset every register reads zero and the interrupt is low.
- R2: Writing control with bit 0 set while the channel is disabled starts a fetch at the next-pointer address; status bit 10 reads 1 from then until the channel is idle again.
- R3: A descriptor is seven words at consecutive word addresses in the order link, source, upper source, destination, byte count, control, CRC address; each read request holds its address stable until acknowledged.
- R4: A nonzero link word is followed to the next descriptor; a zero link word ends the chain, sets end-of-chain (status bit 8) and leaves the channel idle. The current-descriptor register holds the address of the descriptor being processed, the byte-count register its count, and the next-pointer register the link word last read.
- R5: Each descriptor that completes sets end-of-transfer (status bit 9). Writing 1 to bit 9 or bit 8 clears only that flag; writing 0 has no effect.
- R6: A descriptor with byte count zero completes without starting the mover and still sets end-of-transfer.
- R7: For a nonzero count the mover start strobe is high for exactly one cycle with source, destination, count, control bits 3:0 as transaction code and control bit 6 as memory-to-memory mode; the channel then waits for the mover's done strobe.
- R8: A done strobe with a nonzero fault vector sets status bits 1, 2, 3, 5 for fault bits 0, 1, 2, 3, does not set end-of-transfer and halts the channel; each error flag clears when 1 is written to its own bit.
- R9: Setting control bit 1 while enabled and idle makes the channel re-read the link word of the current descriptor, and continue the chain if it is nonzero or set end-of-chain if it is zero. Set while busy, it takes effect when the chain reaches its end.
- R10: Clearing enable while busy lets the current descriptor finish and then idles the channel without following the link and without setting end-of-chain.
- R11: The interrupt output is high while end-of-transfer is set and at least one descriptor completed since end-of-transfer was last cleared had control bit 4 (interrupt enable) set.
- R12: Starting with a zero next pointer sets end-of-chain at once, reads no memory and never shows busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | Mover start strobe |
| mv_src | output | 32 | Transfer source address |
| mv_dst | output | 32 | Transfer destination address |
| mv_len | output | 25 | Transfer byte count |
| mv_code | output | 4 | Transaction code |
| mv_m2m | output | 1 | Memory-to-memory mode |
| mv_done | input | 1 | Mover completion strobe |
| mv_err | input | 4 | Mover fault vector, valid with mv_done |
| irq | output | 1 | Interrupt |

## Verification
The channel is driven with a three-descriptor chain mixing a zero-length entry and two control-word patterns (copy code with memory mode, other code without it), which separates link following, the zero-length shortcut and field routing to the mover. Append is tried idle with a nonzero and a zero link word and again while a transfer is in flight, telling apart immediate and deferred resumption. Single and multiple mover faults, an enable clear in mid-chain and a start on an empty pointer show that each stop path leaves a distinct set of status flags and pointer values behind.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
   localparam int WORD_W = 32;
   localparam int DESC_WORDS = 7;

   // register byte offsets
   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_STAT = 8'h04;
   localparam logic [7:0] OFS_CUR  = 8'h0C;
   localparam logic [7:0] OFS_NEXT = 8'h10;
   localparam logic [7:0] OFS_CNT  = 8'h20;

   // status bit positions
   localparam int ST_BUSY = 10;
   localparam int ST_EOT  = 9;
   localparam int ST_EOC  = 8;
   localparam int ERR_N   = 4;

   // descriptor word indices
   localparam int DW_LINK = 0;
   localparam int DW_SRC  = 1;
   localparam int DW_DST  = 3;
   localparam int DW_CNT  = 4;
   localparam int DW_CTL  = 5;

   // descriptor control word fields
   localparam int CT_IE  = 4;
   localparam int CT_M2M = 6;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_EXEC,
      SQ_WAIT,
      SQ_LINK
   } seq_state_t;

   function automatic int err_bit(input int idx);
      case (idx)
         0:       return 1;
         1:       return 2;
         2:       return 3;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/dcc_seq.sv
module dcc_seq
   import dcc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 25,
   parameter bit FETCH_CRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              start,
   input  logic              app_pend,
   input  logic [AW-1:0]     ndar,
   output logic              app_take,
   output logic              ndar_ld,
   output logic [AW-1:0]     ndar_val,
   output logic              busy,
   output logic [AW-1:0]     cur_desc,
   output logic [LEN_W-1:0]  cur_cnt,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mv_start,
   output logic [AW-1:0]     mv_src,
   output logic [AW-1:0]     mv_dst,
   output logic [LEN_W-1:0]  mv_len,
   output logic [3:0]        mv_code,
   output logic              mv_m2m,
   input  logic              mv_done,
   input  logic [ERR_N-1:0]  mv_err,
   output logic              ev_eot,
   output logic              ev_eot_ie,
   output logic              ev_eoc,
   output logic [ERR_N-1:0]  ev_err
);
   localparam int WI_W = $clog2(DESC_WORDS);

   seq_state_t       st;
   logic [WI_W-1:0]  widx;
   logic [WI_W-1:0]  last_idx;
   logic [AW-1:0]    r_link;
   logic [AW-1:0]    r_src;
   logic [AW-1:0]    r_dst;
   logic [LEN_W-1:0] r_cnt;
   logic [7:0]       r_ctl;
   logic             done_ok;

   // variant: read the trailing CRC word or stop after the control word
   generate
      if (FETCH_CRC) begin : g_full_fetch
         assign last_idx = WI_W'(DESC_WORDS - 1);
      end else begin : g_short_fetch
         assign last_idx = WI_W'(DW_CTL);
      end
   endgenerate

   assign busy     = (st != SQ_IDLE);
   assign mem_req  = (st == SQ_FETCH) || (st == SQ_LINK);
   assign mem_addr = (st == SQ_FETCH) ? cur_desc + AW'({widx, 2'b00}) : cur_desc;
   assign mv_start = (st == SQ_EXEC) && (r_cnt != '0);
   assign mv_src   = r_src;
   assign mv_dst   = r_dst;
   assign mv_len   = r_cnt;
   assign mv_code  = r_ctl[3:0];
   assign mv_m2m   = r_ctl[CT_M2M];
   assign cur_cnt  = r_cnt;
   assign done_ok  = ((st == SQ_EXEC) && (r_cnt == '0)) ||
                     ((st == SQ_WAIT) && mv_done && (mv_err == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         widx      <= '0;
         cur_desc  <= '0;
         r_link    <= '0;
         r_src     <= '0;
         r_dst     <= '0;
         r_cnt     <= '0;
         r_ctl     <= '0;
         app_take  <= 1'b0;
         ndar_ld   <= 1'b0;
         ndar_val  <= '0;
         ev_eot    <= 1'b0;
         ev_eot_ie <= 1'b0;
         ev_eoc    <= 1'b0;
         ev_err    <= '0;
      end else begin
         app_take  <= 1'b0;
         ndar_ld   <= 1'b0;
         ev_eot    <= 1'b0;
         ev_eot_ie <= 1'b0;
         ev_eoc    <= 1'b0;
         ev_err    <= '0;
         unique case (st)
            SQ_IDLE: begin
               if (start) begin
                  if (ndar != '0) begin
                     cur_desc <= ndar;
                     widx     <= '0;
                     st       <= SQ_FETCH;
                  end else begin
                     ev_eoc <= 1'b1;
                  end
               end else if (en && app_pend) begin
                  app_take <= 1'b1;
                  st       <= SQ_LINK;
               end
            end
            SQ_FETCH: begin
               if (mem_ack) begin
                  case (int'(widx))
                     DW_LINK: begin
                        r_link   <= mem_rdata[AW-1:0];
                        ndar_ld  <= 1'b1;
                        ndar_val <= mem_rdata[AW-1:0];
                     end
                     DW_SRC: r_src <= mem_rdata[AW-1:0];
                     DW_DST: r_dst <= mem_rdata[AW-1:0];
                     DW_CNT: r_cnt <= mem_rdata[LEN_W-1:0];
                     DW_CTL: r_ctl <= mem_rdata[7:0];
                     default: ;
                  endcase
                  if (widx == last_idx) st <= SQ_EXEC;
                  else                  widx <= widx + 1'b1;
               end
            end
            SQ_EXEC: begin
               if (r_cnt != '0) st <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (mv_done && (mv_err != '0)) begin
                  ev_err <= mv_err;
                  st     <= SQ_IDLE;
               end
            end
            SQ_LINK: begin
               if (mem_ack) begin
                  ndar_ld  <= 1'b1;
                  ndar_val <= mem_rdata[AW-1:0];
                  if (mem_rdata[AW-1:0] != '0) begin
                     cur_desc <= mem_rdata[AW-1:0];
                     widx     <= '0;
                     st       <= SQ_FETCH;
                  end else begin
                     ev_eoc <= 1'b1;
                     st     <= SQ_IDLE;
                  end
               end
            end
            default: st <= SQ_IDLE;
         endcase
         if (done_ok) begin
            ev_eot    <= 1'b1;
            ev_eot_ie <= r_ctl[CT_IE];
            if (!en) begin
               st <= SQ_IDLE;
            end else if (r_link != '0) begin
               cur_desc <= r_link;
               widx     <= '0;
               st       <= SQ_FETCH;
            end else if (app_pend) begin
               app_take <= 1'b1;
               st       <= SQ_LINK;
            end else begin
               ev_eoc <= 1'b1;
               st     <= SQ_IDLE;
            end
         end
      end
   end

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   p_move_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start |=> !mv_start);
   p_no_empty_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mv_start |-> (mv_len != '0));
   p_fault_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == SQ_WAIT) && mv_done && (mv_err != '0)) |=> !busy);
   p_chain_end_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_eoc |-> !busy);
endmodule

// File: rtl/dcc_csr.sv
module dcc_csr
   import dcc_pkg::*;
#(
   parameter int RA_W  = 8,
   parameter int AW    = 32,
   parameter int LEN_W = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [RA_W-1:0]   cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   output logic              en,
   output logic              start,
   output logic              app_pend,
   input  logic              app_take,
   output logic [AW-1:0]     ndar,
   input  logic              ndar_ld,
   input  logic [AW-1:0]     ndar_val,
   input  logic              busy,
   input  logic [AW-1:0]     cur_desc,
   input  logic [LEN_W-1:0]  cur_cnt,
   input  logic              ev_eot,
   input  logic              ev_eot_ie,
   input  logic              ev_eoc,
   input  logic [ERR_N-1:0]  ev_err,
   output logic              irq
);
   logic             eot_q;
   logic             eoc_q;
   logic             arm_q;
   logic [ERR_N-1:0] err_q;
   logic             wr_ctrl;
   logic             wr_stat;
   logic             wr_next;

   assign wr_ctrl = cfg_we && (cfg_addr == RA_W'(OFS_CTRL));
   assign wr_stat = cfg_we && (cfg_addr == RA_W'(OFS_STAT));
   assign wr_next = cfg_we && (cfg_addr == RA_W'(OFS_NEXT));
   assign start   = wr_ctrl && cfg_wdata[0] && !en;
   assign irq     = eot_q && arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         app_pend <= 1'b0;
         ndar     <= '0;
         eot_q    <= 1'b0;
         eoc_q    <= 1'b0;
         arm_q    <= 1'b0;
      end else begin
         if (wr_ctrl) en <= cfg_wdata[0];
         if (wr_ctrl && !cfg_wdata[0])     app_pend <= 1'b0;
         else if (wr_ctrl && cfg_wdata[1]) app_pend <= 1'b1;
         else if (app_take)                app_pend <= 1'b0;
         if (ndar_ld)      ndar <= ndar_val;
         else if (wr_next) ndar <= cfg_wdata[AW-1:0];
         if (ev_eot)                             eot_q <= 1'b1;
         else if (wr_stat && cfg_wdata[ST_EOT])  eot_q <= 1'b0;
         if (ev_eoc)                             eoc_q <= 1'b1;
         else if (wr_stat && cfg_wdata[ST_EOC])  eoc_q <= 1'b0;
         if (ev_eot && ev_eot_ie)                          arm_q <= 1'b1;
         else if (!ev_eot && wr_stat && cfg_wdata[ST_EOT]) arm_q <= 1'b0;
      end
   end

   generate
      for (genvar gi = 0; gi < ERR_N; gi++) begin : g_err
         localparam int POS = err_bit(gi);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          err_q[gi] <= 1'b0;
            else if (ev_err[gi])                 err_q[gi] <= 1'b1;
            else if (wr_stat && cfg_wdata[POS])  err_q[gi] <= 1'b0;
         end
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      case (cfg_addr)
         RA_W'(OFS_CTRL): cfg_rdata[1:0] = {app_pend, en};
         RA_W'(OFS_STAT): begin
            cfg_rdata[ST_BUSY] = busy;
            cfg_rdata[ST_EOT]  = eot_q;
            cfg_rdata[ST_EOC]  = eoc_q;
            for (int i = 0; i < ERR_N; i++) cfg_rdata[err_bit(i)] = err_q[i];
         end
         RA_W'(OFS_CUR):  cfg_rdata[AW-1:0]    = cur_desc;
         RA_W'(OFS_NEXT): cfg_rdata[AW-1:0]    = ndar;
         RA_W'(OFS_CNT):  cfg_rdata[LEN_W-1:0] = cur_cnt;
         default: ;
      endcase
   end

   p_eot_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && cfg_wdata[ST_EOT] && !ev_eot) |=> !eot_q);
   p_eoc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && cfg_wdata[ST_EOC] && !ev_eoc) |=> !eoc_q);
   p_err_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_err != '0) |=> ((err_q & $past(ev_err)) == $past(ev_err)));
   p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ev_eot));
endmodule

// File: rtl/chain_dma_ch.sv
module chain_dma_ch
   import dcc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LEN_W     = 25,
   parameter int MAX_BYTES = 16777216,
   parameter int RA_W      = 8,
   parameter bit FETCH_CRC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [RA_W-1:0]   cfg_addr,
   input  logic [WORD_W-1:0] cfg_wdata,
   output logic [WORD_W-1:0] cfg_rdata,
   output logic              mem_req,
   output logic [AW-1:0]     mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mv_start,
   output logic [AW-1:0]     mv_src,
   output logic [AW-1:0]     mv_dst,
   output logic [LEN_W-1:0]  mv_len,
   output logic [3:0]        mv_code,
   output logic              mv_m2m,
   input  logic              mv_done,
   input  logic [ERR_N-1:0]  mv_err,
   output logic              irq
);
   generate
      if (LEN_W < $clog2(MAX_BYTES + 1)) begin : g_bad_len
         $error("LEN_W too narrow for MAX_BYTES");
      end
      if (AW > WORD_W || AW < 8) begin : g_bad_aw
         $error("AW must lie between 8 and the word width");
      end
      if (RA_W < 6) begin : g_bad_ra
         $error("RA_W must cover the register offsets");
      end
   endgenerate

   logic             en;
   logic             start;
   logic             app_pend;
   logic             app_take;
   logic [AW-1:0]    ndar;
   logic             ndar_ld;
   logic [AW-1:0]    ndar_val;
   logic             busy;
   logic [AW-1:0]    cur_desc;
   logic [LEN_W-1:0] cur_cnt;
   logic             ev_eot;
   logic             ev_eot_ie;
   logic             ev_eoc;
   logic [ERR_N-1:0] ev_err;

   dcc_csr #(.RA_W(RA_W), .AW(AW), .LEN_W(LEN_W)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .en(en), .start(start), .app_pend(app_pend), .app_take(app_take),
      .ndar(ndar), .ndar_ld(ndar_ld), .ndar_val(ndar_val),
      .busy(busy), .cur_desc(cur_desc), .cur_cnt(cur_cnt),
      .ev_eot(ev_eot), .ev_eot_ie(ev_eot_ie), .ev_eoc(ev_eoc), .ev_err(ev_err),
      .irq(irq)
   );

   dcc_seq #(.AW(AW), .LEN_W(LEN_W), .FETCH_CRC(FETCH_CRC)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .en(en), .start(start), .app_pend(app_pend), .ndar(ndar),
      .app_take(app_take), .ndar_ld(ndar_ld), .ndar_val(ndar_val),
      .busy(busy), .cur_desc(cur_desc), .cur_cnt(cur_cnt),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
      .mv_code(mv_code), .mv_m2m(mv_m2m), .mv_done(mv_done), .mv_err(mv_err),
      .ev_eot(ev_eot), .ev_eot_ie(ev_eot_ie), .ev_eoc(ev_eoc), .ev_err(ev_err)
   );
endmodule

// File: tb/sim_chain_dma_ch.sv
`timescale 1ns/1ps
module sim_chain_dma_ch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mv_start;
   logic [31:0] mv_src, mv_dst;
   logic [24:0] mv_len;
   logic [3:0]  mv_code;
   logic        mv_m2m;
   logic        mv_done = 1'b0;
   logic [3:0]  mv_err = '0;
   logic        irq;

   always #2.5 clk = ~clk;

   chain_dma_ch u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
      .mv_code(mv_code), .mv_m2m(mv_m2m), .mv_done(mv_done), .mv_err(mv_err),
      .irq(irq)
   );

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [24:0] len;
      logic [3:0]  code;
      logic        m2m;
   } mv_t;

   mv_t         exp_q[$];
   logic [31:0] mem [0:255];
   int          n_chk = 0;
   int          n_bad = 0;
   int          mv_delay = 3;
   int          mv_left = 0;
   logic [3:0]  err_inject = '0;
   bit          done_flag = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model: one ack per request, data from the word array
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack   = 1'b1;
         mem_rdata = mem[mem_addr[9:2]];
      end else begin
         mem_ack = 1'b0;
      end
   end

   // mover stub
   always @(negedge clk) begin
      mv_done = 1'b0;
      mv_err  = '0;
      if (mv_start) mv_left = mv_delay;
      else if (mv_left > 0) begin
         mv_left--;
         if (mv_left == 0) begin
            mv_done = 1'b1;
            mv_err  = err_inject;
         end
      end
   end

   // monitor: every mover start is compared with the next expected item (R7)
   always @(negedge clk) begin
      if (rst_n && mv_start) begin
         mv_t got;
         got = '{src: mv_src, dst: mv_dst, len: mv_len, code: mv_code, m2m: mv_m2m};
         if (exp_q.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 unexpected move actual=%h expected=none", got);
         end else begin
            mv_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (got !== e) begin
               n_bad++;
               $display("FAIL R7 move actual=%h expected=%h", got, e);
            end
         end
      end
   end

   task automatic expect_move(input logic [31:0] s, input logic [31:0] d,
                              input logic [24:0] l, input logic [7:0] ctl);
      exp_q.push_back('{src: s, dst: d, len: l, code: ctl[3:0], m2m: ctl[6]});
   endtask

   task automatic put_desc(input int base, input logic [31:0] link, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] cnt, input logic [31:0] ctl);
      mem[(base >> 2) + 0] = link;
      mem[(base >> 2) + 1] = s;
      mem[(base >> 2) + 2] = 32'hDEAD_0002;
      mem[(base >> 2) + 3] = d;
      mem[(base >> 2) + 4] = cnt;
      mem[(base >> 2) + 5] = ctl;
      mem[(base >> 2) + 6] = 32'hDEAD_0006;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(8'h04, s);
         if (!s[10]) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   initial begin
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      if (!done_flag) $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      chk_reg("R1 ctrl", 8'h00, 32'h0);
      chk_reg("R1 status", 8'h04, 32'h0);
      chk_reg("R1 cur", 8'h0C, 32'h0);
      chk_reg("R1 next", 8'h10, 32'h0);
      chk_reg("R1 count", 8'h20, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);

      // R2 R3 R4 R6 R7 R11: chain A -> B(zero length) -> C
      put_desc(32'h100, 32'h140, 32'h1000, 32'h2000, 16, 32'h4E);
      put_desc(32'h140, 32'h180, 32'h1800, 32'h2800, 0, 32'h4E);
      put_desc(32'h180, 32'h0, 32'h3000, 32'h4000, 32, 32'h13);
      expect_move(32'h1000, 32'h2000, 16, 8'h4E);
      expect_move(32'h3000, 32'h4000, 32, 8'h13);
      wr(8'h10, 32'h100);
      wr(8'h00, 32'h1);
      rd(8'h04, v);
      check("R2 busy after enable", {31'b0, v[10]}, 32'h1);
      wait_idle();
      chk_reg("R4 R5 status at chain end", 8'h04, 32'h300);
      chk_reg("R4 cur at last", 8'h0C, 32'h180);
      chk_reg("R4 next follows link", 8'h10, 32'h0);
      chk_reg("R4 count of last", 8'h20, 32'd32);
      check("R11 irq with enabled desc", {31'b0, irq}, 32'h1);
      check("R6 R7 moves consumed", exp_q.size(), 0);

      // R5: write-one-to-clear, independent bits
      wr(8'h04, 32'h200);
      chk_reg("R5 eot cleared only", 8'h04, 32'h100);
      check("R11 irq drops with eot", {31'b0, irq}, 32'h0);
      wr(8'h04, 32'h0);
      chk_reg("R5 zero write no effect", 8'h04, 32'h100);
      wr(8'h04, 32'h100);
      chk_reg("R5 eoc cleared", 8'h04, 32'h0);

      // R9: append while idle, nonzero link
      put_desc(32'h1C0, 32'h0, 32'h5000, 32'h6000, 8, 32'h4E);
      mem[32'h180 >> 2] = 32'h1C0;
      expect_move(32'h5000, 32'h6000, 8, 8'h4E);
      wr(8'h00, 32'h3);
      wait_idle();
      chk_reg("R9 append continues", 8'h0C, 32'h1C0);
      chk_reg("R9 status after append", 8'h04, 32'h300);
      chk_reg("R9 append bit taken", 8'h00, 32'h1);
      check("R11 no irq without enable", {31'b0, irq}, 32'h0);
      check("R9 move consumed", exp_q.size(), 0);

      // R9: append with zero link
      wr(8'h04, 32'h300);
      wr(8'h00, 32'h3);
      wait_idle();
      chk_reg("R9 zero link ends chain", 8'h04, 32'h100);
      chk_reg("R9 cur unchanged", 8'h0C, 32'h1C0);

      // R9: append set while busy, deferred to chain end
      wr(8'h04, 32'h300);
      wr(8'h00, 32'h0);
      mv_delay = 30;
      put_desc(32'h200, 32'h0, 32'h7000, 32'h7800, 64, 32'h4E);
      put_desc(32'h240, 32'h0, 32'h8000, 32'h8800, 4, 32'h4E);
      expect_move(32'h7000, 32'h7800, 64, 8'h4E);
      expect_move(32'h8000, 32'h8800, 4, 8'h4E);
      wr(8'h10, 32'h200);
      wr(8'h00, 32'h1);
      repeat (20) @(negedge clk);
      mem[32'h200 >> 2] = 32'h240;
      wr(8'h00, 32'h3);
      wait_idle();
      chk_reg("R9 deferred append", 8'h0C, 32'h240);
      chk_reg("R9 deferred status", 8'h04, 32'h300);
      check("R9 deferred moves", exp_q.size(), 0);
      mv_delay = 3;

      // R8: single fault halts, maps to bit 5
      wr(8'h04, 32'h300);
      wr(8'h00, 32'h0);
      put_desc(32'h280, 32'h2C0, 32'h9000, 32'h9800, 64, 32'h4E);
      expect_move(32'h9000, 32'h9800, 64, 8'h4E);
      err_inject = 4'b1000;
      wr(8'h10, 32'h280);
      wr(8'h00, 32'h1);
      wait_idle();
      chk_reg("R8 fault bit 5 only", 8'h04, 32'h20);
      chk_reg("R8 halted at faulting desc", 8'h0C, 32'h280);

      // R8: multiple faults, individual clear
      wr(8'h00, 32'h0);
      put_desc(32'h2C0, 32'h0, 32'hA000, 32'hA800, 12, 32'h4E);
      expect_move(32'hA000, 32'hA800, 12, 8'h4E);
      err_inject = 4'b0111;
      wr(8'h10, 32'h2C0);
      wr(8'h00, 32'h1);
      wait_idle();
      chk_reg("R8 fault bits 1 2 3", 8'h04, 32'h2E);
      wr(8'h04, 32'h04);
      chk_reg("R8 clear bit 2 only", 8'h04, 32'h2A);
      wr(8'h04, 32'h2A);
      chk_reg("R8 all faults cleared", 8'h04, 32'h0);
      err_inject = '0;

      // R10: enable cleared mid-chain
      wr(8'h00, 32'h0);
      mv_delay = 30;
      put_desc(32'h300, 32'h340, 32'hB000, 32'hB800, 20, 32'h4E);
      put_desc(32'h340, 32'h0, 32'hC000, 32'hC800, 20, 32'h4E);
      expect_move(32'hB000, 32'hB800, 20, 8'h4E);
      wr(8'h10, 32'h300);
      wr(8'h00, 32'h1);
      repeat (20) @(negedge clk);
      wr(8'h00, 32'h0);
      wait_idle();
      chk_reg("R10 stops without eoc", 8'h04, 32'h200);
      chk_reg("R10 cur at stopped desc", 8'h0C, 32'h300);
      chk_reg("R10 next holds link", 8'h10, 32'h340);
      mv_delay = 3;

      // R12: empty start
      wr(8'h04, 32'h200);
      wr(8'h10, 32'h0);
      wr(8'h00, 32'h1);
      chk_reg("R12 empty start sets eoc", 8'h04, 32'h100);
      chk_reg("R12 cur untouched", 8'h0C, 32'h300);

      // R6 R11: lone zero-length descriptor with interrupt enable
      wr(8'h04, 32'h100);
      wr(8'h00, 32'h0);
      put_desc(32'h380, 32'h0, 32'hD000, 32'hD800, 0, 32'h10);
      wr(8'h10, 32'h380);
      wr(8'h00, 32'h1);
      wait_idle();
      chk_reg("R6 zero length completes", 8'h04, 32'h300);
      chk_reg("R6 count reads zero", 8'h20, 32'h0);
      check("R11 irq from zero-length desc", {31'b0, irq}, 32'h1);
      check("R6 no move queued", exp_q.size(), 0);

      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule